// File: doc/BRIEF.md
# ULPI Link-Side Bus Controller

This block sits on the link side of an 8-bit ULPI-style PHY connection and runs the shared data bus, all on the single interface clock. The PHY's direction input decides who owns the bus in every cycle. When that input changes level, one turnaround cycle follows before either side's data counts. Instead of a real tristate pad, the block has a separate output data bus, an input data bus and an output enable.

Outgoing packet bytes arrive on a valid/ready stream with a last-byte flag. The first byte of a packet is taken without waiting and placed on the bus. After that, each byte moves on only when the PHY's next-data input accepts the byte already on the bus, and the following byte is driven on the next clock. After the last byte has been accepted, the stop output pulses for one clock. If the PHY takes the bus in the middle of a packet, the packet is dropped and an abort pulse goes back upstream instead of a stop.

Bytes from the PHY are captured only in PHY-owned cycles that have next-data high. They leave on a registered receive stream. An end flag pulses after the PHY gives the bus back. A request input lets the link cut an incoming transfer short with a one-cycle stop pulse.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: During reset, `phy_stp`, `rx_valid`, `rx_end` and `tx_abort` are 0 and `bus_do` is 0x00.
- R2: `bus_oe` is 0 in every cycle where `phy_dir` is high. It is also 0 in the turnaround cycle, which is the first cycle where `phy_dir` differs from its value in the previous cycle.
- R3: `tx_ready` is 1 only in a link-owned, non-turnaround cycle with no stop pulse in progress. In addition, either no byte is held on the bus, or `phy_nxt` is 1 and the held byte is not the last of its packet.
- R4: A byte taken from the transmit stream appears on `bus_do`, with `bus_oe` high, from the next clock on. It stays there until `phy_nxt` accepts it, and the following byte appears on the clock after that acceptance.
- R5: The clock after the last byte (`tx_last`=1) is accepted, `phy_stp` is 1 for exactly one cycle and `bus_do` returns to 0x00.
- R6: If `phy_dir` rises while a packet is unfinished, `tx_abort` pulses for one cycle on the next clock, no stop pulse is issued, and the held byte is discarded, so `bus_do` is 0x00 when the link regains the bus.
- R7: The clock after a cycle with the PHY owning the bus (`phy_dir` high, not turnaround) and `phy_nxt` high, `rx_valid` is 1 and `rx_data` equals the `bus_di` value of that cycle. Turnaround cycles and cycles with `phy_nxt` low produce no `rx_valid`.
- R8: If at least one byte was received while `phy_dir` was high, `rx_end` pulses for one clock. The pulse comes on the clock after the first cycle in which `phy_dir` is low again. A hold-off with no bytes gives no `rx_end`.
- R9: `rx_stop_req` high in a PHY-owned cycle gives a one-cycle `phy_stp` on the next clock. In a link-owned cycle it has no effect.
- R10: While `phy_dir` is high, `tx_ready` stays 0 whatever `tx_valid` does, so nothing is taken from the transmit stream during a hold-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_dir | input | 1 | PHY direction: high means the PHY owns the bus |
| phy_nxt | input | 1 | PHY next-data handshake |
| phy_stp | output | 1 | One-cycle stop strobe to the PHY |
| bus_di | input | 8 | Data bus as seen from the pad |
| bus_do | output | 8 | Data the link drives onto the bus |
| bus_oe | output | 1 | Link output enable |
| tx_data | input | 8 | Transmit stream byte |
| tx_valid | input | 1 | Transmit byte valid |
| tx_last | input | 1 | Transmit byte is the last of its packet |
| tx_ready | output | 1 | Transmit byte is taken this cycle |
| tx_abort | output | 1 | Packet dropped because the PHY took the bus |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte valid |
| rx_end | output | 1 | Incoming transfer finished |
| rx_stop_req | input | 1 | Request to end the incoming transfer |

## Verification
The critical overlap is between the PHY raising direction and the handshake that would accept the last byte of a packet. Both can fall in one cycle, and the result decides between a stop pulse and an abort. The bench holds a single last-flagged byte and then raises `phy_dir` together with `phy_nxt` in the same cycle. It judges the result by `tx_abort` pulsing and `phy_stp` staying low over the following two clocks. A second overlap is the stop request meeting the PHY's release of the bus. This case is judged by `phy_stp` and `rx_end` landing in consecutive cycles and never together.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;
  parameter int unsigned ULPI_W = 8;

  typedef enum logic [1:0] {
    OWN_LINK = 2'd0,
    OWN_TURN = 2'd1,
    OWN_PHY  = 2'd2
  } bus_own_e;
endpackage

// File: rtl/ulpi_dir_track.sv
module ulpi_dir_track
  import ulpi_link_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     phy_dir,
  output logic     dir_q,
  output bus_own_e owner
);
  logic dir_n;

  always_comb dir_n = phy_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_n;
  end

  always_comb begin
    if (phy_dir != dir_q) owner = OWN_TURN;
    else if (phy_dir)     owner = OWN_PHY;
    else                  owner = OWN_LINK;
  end
endmodule

// File: rtl/ulpi_tx_path.sv
module ulpi_tx_path
  import ulpi_link_pkg::*;
#(
  parameter int unsigned W = ULPI_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bus_own_e     owner,
  input  logic         phy_dir,
  input  logic         phy_nxt,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  input  logic         tx_last,
  output logic         tx_ready,
  output logic         tx_abort,
  output logic         tx_stp,
  output logic [W-1:0] bus_do
);
  logic [W-1:0] hold_d;
  logic         hold_v, hold_v_n;
  logic         hold_l, hold_l_n;
  logic         in_pkt, in_pkt_n;
  logic         stp_n, abort_n;
  logic         link_own, accept, load;

  always_comb begin
    link_own = (owner == OWN_LINK);
    accept   = link_own & hold_v & phy_nxt;
    tx_ready = link_own & ~tx_stp & (~hold_v | (phy_nxt & ~hold_l));
    load     = tx_valid & tx_ready;
  end

  always_comb begin
    hold_v_n = hold_v;
    hold_l_n = hold_l;
    in_pkt_n = in_pkt;
    stp_n    = 1'b0;
    abort_n  = 1'b0;
    if (accept) begin
      hold_v_n = 1'b0;
      if (hold_l) begin
        stp_n    = 1'b1;
        in_pkt_n = 1'b0;
      end
    end
    if (load) begin
      hold_v_n = 1'b1;
      hold_l_n = tx_last;
      in_pkt_n = 1'b1;
    end
    if (phy_dir && in_pkt) begin
      abort_n  = 1'b1;
      in_pkt_n = 1'b0;
      hold_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_l   <= 1'b0;
      in_pkt   <= 1'b0;
      tx_stp   <= 1'b0;
      tx_abort <= 1'b0;
    end else begin
      hold_v   <= hold_v_n;
      hold_l   <= hold_l_n;
      in_pkt   <= in_pkt_n;
      tx_stp   <= stp_n;
      tx_abort <= abort_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_d <= '0;
    else if (load) hold_d <= tx_data;
  end

  always_comb bus_do = hold_v ? hold_d : '0;

  assert_ready_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (owner == OWN_LINK) && !phy_dir);
  assert_stp_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stp |=> !tx_stp);
  assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> !tx_stp);
  assert_holdoff_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phy_dir |-> !tx_ready);
endmodule

// File: rtl/ulpi_rx_path.sv
module ulpi_rx_path
  import ulpi_link_pkg::*;
#(
  parameter int unsigned W = ULPI_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bus_own_e     owner,
  input  logic         phy_dir,
  input  logic         phy_nxt,
  input  logic [W-1:0] bus_di,
  input  logic         rx_stop_req,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic         rx_end,
  output logic         rx_stp
);
  logic phy_own, cap, fell;
  logic had, had_n, end_n, stp_n;

  always_comb begin
    phy_own = (owner == OWN_PHY);
    cap     = phy_own & phy_nxt;
    fell    = (owner == OWN_TURN) & ~phy_dir;
    had_n   = had;
    if (cap)  had_n = 1'b1;
    if (fell) had_n = 1'b0;
    end_n   = fell & had;
    stp_n   = phy_own & rx_stop_req & ~rx_stp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      had      <= 1'b0;
      rx_valid <= 1'b0;
      rx_end   <= 1'b0;
      rx_stp   <= 1'b0;
    end else begin
      had      <= had_n;
      rx_valid <= cap;
      rx_end   <= end_n;
      rx_stp   <= stp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rx_data <= '0;
    else if (cap) rx_data <= bus_di;
  end

  assert_rx_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(phy_dir) && $past(phy_nxt));
  assert_end_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> !$past(phy_dir));
  assert_rx_stop_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stp |-> $past(phy_dir));
endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl
  import ulpi_link_pkg::*;
#(
  parameter int unsigned DATA_W = ULPI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_dir,
  input  logic              phy_nxt,
  output logic              phy_stp,
  input  logic [DATA_W-1:0] bus_di,
  output logic [DATA_W-1:0] bus_do,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  output logic              tx_abort,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_end,
  input  logic              rx_stop_req
);
  logic [1:0] rst_q;
  logic       rst_s;
  logic       dir_q;
  bus_own_e   owner;
  logic       tx_stp, rx_stp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  always_comb rst_s = rst_q[1];

  ulpi_dir_track u_dir (
    .clk(clk), .rst_n(rst_s), .phy_dir(phy_dir), .dir_q(dir_q), .owner(owner)
  );

  ulpi_tx_path #(.W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_s), .owner(owner), .phy_dir(phy_dir), .phy_nxt(phy_nxt),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_abort(tx_abort), .tx_stp(tx_stp), .bus_do(bus_do)
  );

  ulpi_rx_path #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_s), .owner(owner), .phy_dir(phy_dir), .phy_nxt(phy_nxt),
    .bus_di(bus_di), .rx_stop_req(rx_stop_req),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_end(rx_end), .rx_stp(rx_stp)
  );

  always_comb begin
    bus_oe  = (owner == OWN_LINK);
    phy_stp = tx_stp | rx_stp;
  end

  assert_turn_release_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(phy_dir) |-> !bus_oe);
  assert_dir_release_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (phy_dir && dir_q) |-> !bus_oe);
  assert_single_stop_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !(tx_stp && rx_stp));
endmodule

// File: tb/tb_ulpi_link_ctrl.sv
`timescale 1ns/1ps
module tb_ulpi_link_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       phy_dir, phy_nxt, phy_stp;
  logic [7:0] bus_di, bus_do, tx_data, rx_data;
  logic       bus_oe, tx_valid, tx_last, tx_ready, tx_abort;
  logic       rx_valid, rx_end, rx_stop_req;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  ulpi_link_ctrl dut (
    .clk(clk), .rst_n(rst_n), .phy_dir(phy_dir), .phy_nxt(phy_nxt), .phy_stp(phy_stp),
    .bus_di(bus_di), .bus_do(bus_do), .bus_oe(bus_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_abort(tx_abort),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_end(rx_end), .rx_stop_req(rx_stop_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic idle();
    phy_dir = 0; phy_nxt = 0; bus_di = 0; tx_valid = 0; tx_last = 0;
    tx_data = 0; rx_stop_req = 0;
  endtask

  task automatic t_reset();
    idle(); rst_n = 0;
    step(); step();
    chk("R1 stp", {7'd0, phy_stp}, 8'd0);
    chk("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
    chk("R1 rx_end", {7'd0, rx_end}, 8'd0);
    chk("R1 abort", {7'd0, tx_abort}, 8'd0);
    chk("R1 bus_do", bus_do, 8'h00);
    rst_n = 1;
    repeat (4) step();
  endtask

  task automatic t_tx_packet();
    tx_valid = 1; tx_data = 8'hA1; tx_last = 0; #1;
    chk("R3 first ready", {7'd0, tx_ready}, 8'd1);
    step();
    chk("R4 byte0", bus_do, 8'hA1);
    chk("R4 oe", {7'd0, bus_oe}, 8'd1);
    tx_data = 8'hB2; #1;
    chk("R3 wait nxt", {7'd0, tx_ready}, 8'd0);
    step();
    chk("R4 held", bus_do, 8'hA1);
    phy_nxt = 1; #1;
    chk("R3 nxt ready", {7'd0, tx_ready}, 8'd1);
    step();
    chk("R4 byte1", bus_do, 8'hB2);
    tx_data = 8'hC3; tx_last = 1;
    step();
    chk("R4 byte2", bus_do, 8'hC3);
    chk("R5 no early stp", {7'd0, phy_stp}, 8'd0);
    tx_valid = 0; tx_last = 0; #1;
    chk("R3 last held", {7'd0, tx_ready}, 8'd0);
    step();
    chk("R5 stp", {7'd0, phy_stp}, 8'd1);
    chk("R5 bus idle", bus_do, 8'h00);
    chk("R3 stp cycle", {7'd0, tx_ready}, 8'd0);
    phy_nxt = 0;
    step();
    chk("R5 stp one clock", {7'd0, phy_stp}, 8'd0);
    idle(); step();
  endtask

  task automatic t_tx_abort();
    tx_valid = 1; tx_data = 8'h11; tx_last = 0;
    step();
    tx_data = 8'h22; phy_nxt = 1;
    step();
    chk("R4 abort pre", bus_do, 8'h22);
    phy_dir = 1; phy_nxt = 0; tx_data = 8'h33; #1;
    chk("R2 oe at rise", {7'd0, bus_oe}, 8'd0);
    chk("R10 ready at rise", {7'd0, tx_ready}, 8'd0);
    step();
    chk("R6 abort", {7'd0, tx_abort}, 8'd1);
    chk("R6 no stp", {7'd0, phy_stp}, 8'd0);
    chk("R10 ready held", {7'd0, tx_ready}, 8'd0);
    tx_valid = 0;
    step();
    chk("R6 abort pulse", {7'd0, tx_abort}, 8'd0);
    chk("R6 no stp later", {7'd0, phy_stp}, 8'd0);
    phy_dir = 0; #1;
    chk("R2 turnaround", {7'd0, bus_oe}, 8'd0);
    step();
    chk("R2 regain", {7'd0, bus_oe}, 8'd1);
    chk("R6 discarded", bus_do, 8'h00);
    idle(); step();
  endtask

  task automatic t_collision();
    tx_valid = 1; tx_data = 8'h5C; tx_last = 1;
    step();
    tx_valid = 0; tx_last = 0; phy_dir = 1; phy_nxt = 1;
    step();
    chk("R6 collide abort", {7'd0, tx_abort}, 8'd1);
    chk("R6 collide no stp", {7'd0, phy_stp}, 8'd0);
    phy_nxt = 0;
    step();
    chk("R6 collide no stp2", {7'd0, phy_stp}, 8'd0);
    phy_dir = 0;
    step();
    chk("R8 no bytes no end", {7'd0, rx_end}, 8'd0);
    idle(); step();
  endtask

  task automatic t_rx();
    phy_dir = 1; phy_nxt = 1; bus_di = 8'hEE;
    step();
    chk("R7 turnaround ignored", {7'd0, rx_valid}, 8'd0);
    bus_di = 8'h5A;
    step();
    chk("R7 valid", {7'd0, rx_valid}, 8'd1);
    chk("R7 data", rx_data, 8'h5A);
    phy_nxt = 0; bus_di = 8'hFF;
    step();
    chk("R7 nxt low", {7'd0, rx_valid}, 8'd0);
    phy_nxt = 1; bus_di = 8'hC3;
    step();
    chk("R7 data2", rx_data, 8'hC3);
    chk("R8 no early end", {7'd0, rx_end}, 8'd0);
    phy_dir = 0; phy_nxt = 0; #1;
    chk("R2 fall turn", {7'd0, bus_oe}, 8'd0);
    step();
    chk("R8 end", {7'd0, rx_end}, 8'd1);
    chk("R7 no valid at end", {7'd0, rx_valid}, 8'd0);
    step();
    chk("R8 end pulse", {7'd0, rx_end}, 8'd0);
    idle(); step();
  endtask

  task automatic t_holdoff();
    phy_dir = 1; tx_valid = 1; tx_data = 8'h77;
    for (int i = 0; i < 3; i++) begin
      #1; chk("R10 holdoff ready", {7'd0, tx_ready}, 8'd0);
      step();
      chk("R8 holdoff no valid", {7'd0, rx_valid}, 8'd0);
    end
    tx_valid = 0; phy_dir = 0;
    step();
    chk("R8 holdoff no end", {7'd0, rx_end}, 8'd0);
    step();
    chk("R10 nothing taken", bus_do, 8'h00);
    idle(); step();
  endtask

  task automatic t_rx_stop();
    rx_stop_req = 1;
    step();
    chk("R9 link-owned ignored", {7'd0, phy_stp}, 8'd0);
    rx_stop_req = 0; phy_dir = 1;
    step();
    phy_nxt = 1; bus_di = 8'h01;
    step();
    phy_nxt = 0; rx_stop_req = 1;
    step();
    chk("R9 stop", {7'd0, phy_stp}, 8'd1);
    chk("R8 not yet", {7'd0, rx_end}, 8'd0);
    rx_stop_req = 0; phy_dir = 0;
    step();
    chk("R9 stop one clock", {7'd0, phy_stp}, 8'd0);
    chk("R8 end after stop", {7'd0, rx_end}, 8'd1);
    idle(); step();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_tx_packet();
        t_tx_abort();
        t_collision();
        t_rx();
        t_holdoff();
        t_rx_stop();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule